// File: doc/BRIEF.md
# APB Peripheral Protection Gate

This block sits between one APB4 requester and up to sixteen downstream peripheral ports. An external address decoder raises one bit of a one-hot select for each transfer. The gate checks the transfer's protection attributes against fixed per-port permissions and either passes the transfer to the selected port or stops it. All permissions arrive on input wires. The block has no registers that software can program.

A transfer that passes reaches the selected port unchanged, and the port's response returns to the requester. A transfer that is refused never selects a peripheral. The gate then completes the transfer itself. One mode input sets the answer: either an error response, or read-as-zero/write-ignored with an OKAY response. Every refusal sets a sticky pending flag. A registered interrupt output reports that flag when interrupts are enabled, and a clear input drops it.

An elaboration mask lets chosen ports skip the security comparison. The privilege comparison still applies on those ports.

Top module: `apb_prot_gate`

## Requirements
- R1: When a transfer is allowed, `m_psel` equals `s_psel`. Address, write data, strobes, direction, enable and protection reach the ports unchanged. `s_prdata`, `s_pready` and `s_pslverr` come from the selected port.
- R2: Security check. `s_pprot[1]`=1 marks a non-secure transfer. A transfer to port p is refused when `s_pprot[1]` differs from `cfg_ns_ok[p]`, so a secure transfer to a port configured non-secure is also refused.
- R3: Privilege check. `s_pprot[0]`=0 marks an unprivileged transfer. Such a transfer to port p is refused when `cfg_user_ok[p]`=0.
- R4: For a refused transfer, every bit of `m_psel` stays 0, `s_pready` is 1 and `s_prdata` is zero.
- R5: For a refused transfer, `s_pslverr` equals `cfg_err_resp`. When it is 0, the read returns zero, the write is dropped and the response is OKAY.
- R6: When bit p of parameter `BYPASS_MASK` is set, port p skips the R2 check and still applies the R3 check.
- R7: A refused transfer in its access phase (`s_penable`=1) sets the pending flag. `irq` is a register that resets to 0. After each clock edge it equals the pending flag after that edge ANDed with `irq_en` sampled at that edge.
- R8: `irq_clr`=1 clears the pending flag. While `irq_clr` is held high, refusals do not set the flag.
- R9: While `irq_en`=0, `irq` is 0. A pending flag is kept and shows on `irq` once `irq_en` returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| s_psel | input | NPORT | One-hot port select from the external decoder |
| s_penable | input | 1 | APB access phase |
| s_pwrite | input | 1 | Write when 1 |
| s_paddr | input | AW | Address |
| s_pwdata | input | DW | Write data |
| s_pstrb | input | DW/8 | Write byte strobes |
| s_pprot | input | 3 | Protection: bit0 privileged, bit1 non-secure, bit2 instruction |
| s_prdata | output | DW | Read data to requester |
| s_pready | output | 1 | Transfer complete |
| s_pslverr | output | 1 | Error response |
| m_psel | output | NPORT | Gated per-port select |
| m_penable | output | 1 | Forwarded enable |
| m_pwrite | output | 1 | Forwarded direction |
| m_paddr | output | AW | Forwarded address |
| m_pwdata | output | DW | Forwarded write data |
| m_pstrb | output | DW/8 | Forwarded strobes |
| m_pprot | output | 3 | Forwarded protection |
| m_prdata | input | NPORT*DW | Read data of all ports, port p at bits p*DW upward |
| m_pready | input | NPORT | Ready of each port |
| m_pslverr | input | NPORT | Error of each port |
| cfg_ns_ok | input | NPORT | Per port: 1 = non-secure transfers allowed |
| cfg_user_ok | input | NPORT | Per port: 1 = unprivileged transfers allowed |
| cfg_err_resp | input | 1 | Refusal answer: 1 error, 0 read-zero/write-ignore |
| irq_en | input | 1 | Interrupt enable |
| irq_clr | input | 1 | Clear pending interrupt |
| irq | output | 1 | Registered refusal interrupt |

## Verification
The assertions check the following on every cycle:
- a refused transfer never leaves a port selected;
- a refused transfer is completed with zero data;
- its error flag follows the mode input;
- the forwarded select is at most one-hot and never outside the requested one;
- the interrupt obeys its clear, enable and set rules.

Only the bench scenarios can show that the right transfers are refused. This covers the security mismatch in both directions, the privilege gate, and the bypass mask that removes only the security check. The scenarios also show that an allowed transfer returns the selected port's own data and error, and that a pending flag outlives a masked enable.

// File: rtl/apb_gate_pkg.sv
// Package: protection-attribute bit positions and the per-port refusal rule.
// Assumes APB4 PPROT encoding: bit0 privileged, bit1 non-secure.
package apb_gate_pkg;
    localparam int PROT_PRIV_BIT = 0;
    localparam int PROT_NS_BIT   = 1;

    // Returns 1 when a transfer with attributes prot must be refused by a port.
    function automatic logic port_refuses(input logic       skip_sec,
                                          input logic       ns_ok,
                                          input logic       user_ok,
                                          input logic [2:0] prot);
        logic sec_bad;
        logic priv_bad;
        sec_bad  = !skip_sec && (prot[PROT_NS_BIT] != ns_ok);
        priv_bad = !prot[PROT_PRIV_BIT] && !user_ok;
        return sec_bad || priv_bad;
    endfunction
endpackage

// File: rtl/apb_gate_perm.sv
// Module: per-port permission evaluation.
// Computes, for every port, whether the current attributes would be refused.
// Assumes configuration inputs are static during a transfer.
module apb_gate_perm #(
    parameter int                NPORT       = 16,
    parameter logic [NPORT-1:0]  BYPASS_MASK = '0
) (
    input  logic [NPORT-1:0] cfg_ns_ok,
    input  logic [NPORT-1:0] cfg_user_ok,
    input  logic [2:0]       prot,
    output logic [NPORT-1:0] refuse_vec
);
    import apb_gate_pkg::*;

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        // Evaluate the refusal rule for port p.
        always_comb begin
            refuse_vec[p] = port_refuses(BYPASS_MASK[p], cfg_ns_ok[p],
                                         cfg_user_ok[p], prot);
        end
    end
endmodule

// File: rtl/apb_gate_resp.sv
// Module: response multiplexer.
// Returns the selected port's response, or a locally generated completion when
// the transfer was refused. Assumes sel_fwd is one-hot or zero.
module apb_gate_resp #(
    parameter int NPORT = 16,
    parameter int DW    = 32
) (
    input  logic [NPORT-1:0]    sel_fwd,
    input  logic                refused,
    input  logic                err_mode,
    input  logic [NPORT*DW-1:0] m_prdata,
    input  logic [NPORT-1:0]    m_pready,
    input  logic [NPORT-1:0]    m_pslverr,
    output logic [DW-1:0]       s_prdata,
    output logic                s_pready,
    output logic                s_pslverr
);
    logic [DW-1:0] mux_data;
    logic          mux_ready;
    logic          mux_err;

    // AND-OR select of the forwarded port's response.
    always_comb begin
        mux_data  = '0;
        mux_ready = 1'b0;
        mux_err   = 1'b0;
        for (int p = 0; p < NPORT; p++) begin
            mux_data  = mux_data  | (m_prdata[p*DW +: DW] & {DW{sel_fwd[p]}});
            mux_ready = mux_ready | (m_pready[p]  & sel_fwd[p]);
            mux_err   = mux_err   | (m_pslverr[p] & sel_fwd[p]);
        end
    end

    // Refused transfers complete at once with zero data and the chosen error.
    always_comb begin
        if (refused) begin
            s_prdata  = '0;
            s_pready  = 1'b1;
            s_pslverr = err_mode;
        end else begin
            s_prdata  = mux_data;
            s_pready  = mux_ready;
            s_pslverr = mux_err;
        end
    end
endmodule

// File: rtl/apb_gate_irq.sv
// Module: sticky refusal interrupt.
// Holds a pending flag set by refusals, cleared by clr (clear wins), and
// drives a registered interrupt gated by enable.
module apb_gate_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic refuse_evt,
    input  logic en,
    input  logic clr,
    output logic irq
);
    logic pend_q;
    logic pend_d;

    // Next pending state: clear has priority over a new refusal.
    always_comb begin
        if (clr)             pend_d = 1'b0;
        else if (refuse_evt) pend_d = 1'b1;
        else                 pend_d = pend_q;
    end

    // Register pending flag and gated interrupt output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            irq    <= 1'b0;
        end else begin
            pend_q <= pend_d;
            irq    <= pend_d & en;
        end
    end
endmodule

// File: rtl/apb_prot_gate.sv
// Module: APB peripheral protection gate (top).
// Forwards allowed transfers to the decoder-selected port and completes refused
// ones locally. Assumes s_psel is one-hot or zero and configuration is static.
module apb_prot_gate #(
    parameter int               NPORT       = 16,
    parameter int               AW          = 32,
    parameter int               DW          = 32,
    parameter logic [NPORT-1:0] BYPASS_MASK = '0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NPORT-1:0]    s_psel,
    input  logic                s_penable,
    input  logic                s_pwrite,
    input  logic [AW-1:0]       s_paddr,
    input  logic [DW-1:0]       s_pwdata,
    input  logic [DW/8-1:0]     s_pstrb,
    input  logic [2:0]          s_pprot,
    output logic [DW-1:0]       s_prdata,
    output logic                s_pready,
    output logic                s_pslverr,
    output logic [NPORT-1:0]    m_psel,
    output logic                m_penable,
    output logic                m_pwrite,
    output logic [AW-1:0]       m_paddr,
    output logic [DW-1:0]       m_pwdata,
    output logic [DW/8-1:0]     m_pstrb,
    output logic [2:0]          m_pprot,
    input  logic [NPORT*DW-1:0] m_prdata,
    input  logic [NPORT-1:0]    m_pready,
    input  logic [NPORT-1:0]    m_pslverr,
    input  logic [NPORT-1:0]    cfg_ns_ok,
    input  logic [NPORT-1:0]    cfg_user_ok,
    input  logic                cfg_err_resp,
    input  logic                irq_en,
    input  logic                irq_clr,
    output logic                irq
);
    logic [NPORT-1:0] refuse_vec;
    logic             refused;

    apb_gate_perm #(.NPORT(NPORT), .BYPASS_MASK(BYPASS_MASK)) u_perm (
        .cfg_ns_ok   (cfg_ns_ok),
        .cfg_user_ok (cfg_user_ok),
        .prot        (s_pprot),
        .refuse_vec  (refuse_vec)
    );

    // A transfer is refused when its selected port refuses it.
    always_comb begin
        refused = |(s_psel & refuse_vec);
    end

    // Gate the selects and pass the shared bus fields through.
    always_comb begin
        m_psel    = s_psel & {NPORT{!refused}};
        m_penable = s_penable;
        m_pwrite  = s_pwrite;
        m_paddr   = s_paddr;
        m_pwdata  = s_pwdata;
        m_pstrb   = s_pstrb;
        m_pprot   = s_pprot;
    end

    apb_gate_resp #(.NPORT(NPORT), .DW(DW)) u_resp (
        .sel_fwd   (m_psel),
        .refused   (refused),
        .err_mode  (cfg_err_resp),
        .m_prdata  (m_prdata),
        .m_pready  (m_pready),
        .m_pslverr (m_pslverr),
        .s_prdata  (s_prdata),
        .s_pready  (s_pready),
        .s_pslverr (s_pslverr)
    );

    apb_gate_irq u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .refuse_evt (refused & s_penable),
        .en         (irq_en),
        .clr        (irq_clr),
        .irq        (irq)
    );
endmodule

// File: rtl/apb_gate_chk.sv
// Module: property checker for apb_prot_gate, attached by bind below.
module apb_gate_chk #(
    parameter int NPORT = 16,
    parameter int DW    = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NPORT-1:0] s_psel,
    input logic             s_penable,
    input logic [NPORT-1:0] m_psel,
    input logic [DW-1:0]    s_prdata,
    input logic             s_pready,
    input logic             s_pslverr,
    input logic             cfg_err_resp,
    input logic             irq_en,
    input logic             irq_clr,
    input logic             irq
);
    logic blocked;
    assign blocked = (|s_psel) && (m_psel == '0);

    // R1
    fwd_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((m_psel & ~s_psel) == '0) && $onehot0(m_psel));

    // R4
    blocked_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        blocked |-> (s_pready && s_prdata == '0));

    // R5
    blocked_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        blocked |-> (s_pslverr == cfg_err_resp));

    // R7
    irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (blocked && s_penable && irq_en && !irq_clr) |=> irq);

    // R8
    irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_clr |=> !irq);

    // R9
    irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |=> !irq);
endmodule

bind apb_prot_gate apb_gate_chk #(.NPORT(NPORT), .DW(DW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .s_psel       (s_psel),
    .s_penable    (s_penable),
    .m_psel       (m_psel),
    .s_prdata     (s_prdata),
    .s_pready     (s_pready),
    .s_pslverr    (s_pslverr),
    .cfg_err_resp (cfg_err_resp),
    .irq_en       (irq_en),
    .irq_clr      (irq_clr),
    .irq          (irq)
);

// File: tb/apb_prot_gate_bench.sv
module apb_prot_gate_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NPORT = 16;
    localparam int AW = 32;
    localparam int DW = 32;
    localparam logic [NPORT-1:0] BYP = 16'h8000;

    logic clk = 0;
    logic rst_n = 0;
    logic [NPORT-1:0] s_psel = '0;
    logic s_penable = 0, s_pwrite = 0;
    logic [AW-1:0] s_paddr = '0;
    logic [DW-1:0] s_pwdata = '0;
    logic [DW/8-1:0] s_pstrb = '0;
    logic [2:0] s_pprot = '0;
    logic [DW-1:0] s_prdata;
    logic s_pready, s_pslverr;
    logic [NPORT-1:0] m_psel;
    logic m_penable, m_pwrite;
    logic [AW-1:0] m_paddr;
    logic [DW-1:0] m_pwdata;
    logic [DW/8-1:0] m_pstrb;
    logic [2:0] m_pprot;
    logic [NPORT*DW-1:0] m_prdata;
    logic [NPORT-1:0] m_pready = '1;
    logic [NPORT-1:0] m_pslverr;
    logic [NPORT-1:0] cfg_ns_ok = 16'h0002;
    logic [NPORT-1:0] cfg_user_ok = 16'h000B;
    logic [NPORT-1:0] ds_err = 16'h0008;
    logic cfg_err_resp = 1, irq_en = 0, irq_clr = 0;
    logic irq;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic [DW-1:0] rdata;
        logic          err;
        logic          fwd;
        string         req;
    } exp_t;
    exp_t exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    apb_prot_gate #(.NPORT(NPORT), .AW(AW), .DW(DW), .BYPASS_MASK(BYP)) u_apb_prot_gate (
        .clk(clk), .rst_n(rst_n), .s_psel(s_psel), .s_penable(s_penable),
        .s_pwrite(s_pwrite), .s_paddr(s_paddr), .s_pwdata(s_pwdata),
        .s_pstrb(s_pstrb), .s_pprot(s_pprot), .s_prdata(s_prdata),
        .s_pready(s_pready), .s_pslverr(s_pslverr), .m_psel(m_psel),
        .m_penable(m_penable), .m_pwrite(m_pwrite), .m_paddr(m_paddr),
        .m_pwdata(m_pwdata), .m_pstrb(m_pstrb), .m_pprot(m_pprot),
        .m_prdata(m_prdata), .m_pready(m_pready), .m_pslverr(m_pslverr),
        .cfg_ns_ok(cfg_ns_ok), .cfg_user_ok(cfg_user_ok),
        .cfg_err_resp(cfg_err_resp), .irq_en(irq_en), .irq_clr(irq_clr),
        .irq(irq)
    );

    // Downstream port models: data identifies port and address.
    function automatic logic [DW-1:0] port_data(int p, logic [AW-1:0] a);
        return 32'hA500_0000 | (32'(p) << 8) | {24'h0, a[7:0]};
    endfunction

    always_comb begin
        for (int p = 0; p < NPORT; p++)
            m_prdata[p*DW +: DW] = port_data(p, m_paddr);
        m_pslverr = ds_err;
    end

    task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Allowance from R2, R3, R6.
    function automatic logic allowed(int p, logic [2:0] prot);
        logic sec_ok, priv_ok;
        sec_ok  = BYP[p] || (prot[1] == cfg_ns_ok[p]);
        priv_ok = prot[0] || cfg_user_ok[p];
        return sec_ok && priv_ok;
    endfunction

    // Driver: push expectation, run one two-phase APB transfer.
    task automatic xfer(int p, logic [2:0] prot, logic wr, string req);
        exp_t e;
        logic [AW-1:0] a;
        a = AW'(32'h100 + p * 4);
        e.fwd   = allowed(p, prot);
        e.rdata = e.fwd ? port_data(p, a) : '0;
        e.err   = e.fwd ? ds_err[p] : cfg_err_resp;
        e.req   = req;
        exp_q.push_back(e);
        @(posedge clk); #1;
        s_psel = NPORT'(1) << p; s_pprot = prot; s_pwrite = wr;
        s_paddr = a; s_pwdata = 32'hC0DE_0000 | p; s_pstrb = '1;
        @(posedge clk); #1;
        s_penable = 1;
        @(posedge clk); #1;
        s_penable = 0; s_psel = '0;
    endtask

    // Monitor: compare each access phase against the scoreboard.
    always @(negedge clk) begin
        if (rst_n && s_penable && (|s_psel)) begin
            if (exp_q.size() == 0) begin
                check("R1 unexpected transfer", 1, 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check({e.req, " rdata"}, s_prdata, e.rdata);
                check({e.req, " pslverr"}, 32'(s_pslverr), 32'(e.err));
                check({e.req, " pready"}, 32'(s_pready), 1);
                check({e.req, " m_psel"}, 32'(m_psel), e.fwd ? 32'(s_psel) : 0);
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 50000);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R7 reset irq", 32'(irq), 0);
        check("R4 reset m_psel", 32'(m_psel), 0);
        @(posedge clk); #1; rst_n = 1;

        cfg_err_resp = 1;
        xfer(0,  3'b001, 0, "R1 secure pass");
        xfer(0,  3'b011, 0, "R2 R5 nonsecure refused error");
        xfer(1,  3'b001, 0, "R2 secure to nonsecure port refused");
        xfer(1,  3'b011, 1, "R1 nonsecure write pass");
        cfg_err_resp = 0;
        xfer(2,  3'b000, 0, "R3 R5 unpriv read zero");
        xfer(2,  3'b001, 0, "R3 priv pass");
        xfer(2,  3'b000, 1, "R4 R5 unpriv write dropped");
        xfer(3,  3'b001, 0, "R1 port error passes through");
        xfer(15, 3'b011, 0, "R6 bypass nonsecure pass");
        xfer(15, 3'b001, 0, "R6 bypass secure pass");
        xfer(15, 3'b010, 0, "R6 bypass privilege still refuses");

        // Pending set while masked.
        @(negedge clk);
        check("R9 masked irq", 32'(irq), 0);
        irq_en = 1;
        @(posedge clk); @(negedge clk);
        check("R9 pending kept", 32'(irq), 1);
        irq_clr = 1;
        @(posedge clk); @(negedge clk);
        check("R8 cleared", 32'(irq), 0);
        xfer(0, 3'b011, 0, "R8 refused during clear");
        @(negedge clk);
        check("R8 no set while clear", 32'(irq), 0);
        irq_clr = 0;
        @(posedge clk); @(negedge clk);
        check("R8 stays clear", 32'(irq), 0);
        xfer(2, 3'b000, 0, "R7 refused sets");
        @(negedge clk);
        check("R7 irq set", 32'(irq), 1);

        check("R1 scoreboard drained", 32'(exp_q.size()), 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule